// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receiving end of a frame-based monitor channel. Once per frame, signalled by a one-cycle strobe, it samples a monitor byte and an active-low send-indicator bit (E) from the far end. It replies on an active-low acknowledge bit (A). A byte is taken only when the same value has been seen in two consecutive frames. The receiver encodes pre-acknowledge, acknowledge and abort as timed patterns on A, and these patterns differ between the first byte of a message and the later ones.

A message opens when E falls while a first byte is presented. After the first byte is accepted, each further byte is announced by E going high for exactly one frame. E staying high for a second frame closes the message. Every accepted byte goes to the downstream consumer on a one-cycle pulse with a first-of-message flag. End of message and abort are reported on pulses of their own. The receiver never stalls the sender. Line serialization and the tri-state driver are handled elsewhere.

Top module: `mon_rx`

## Requirements
- R1: After reset, and whenever no message is open, `ack_n` is 1 and none of `byte_vld`, `msg_end`, `msg_abort` pulse.
- R2: A message opens only on a strobe where `snd_n` is 0 and `snd_n` was 1 at the previous strobe (1 at the first strobe after reset). The opening frame gives no acknowledge.
- R3: On the next strobe, with `snd_n` still 0 and the byte equal to the opening byte, `ack_n` goes to 0 and `byte_vld` pulses with `byte_first`=1 and that byte. `ack_n` then stays 0 while `snd_n` stays 0.
- R4: If the first byte's two most recent copies differ, no acknowledge and no abort are given. The newest copy becomes the reference, and the next identical copy is accepted as in R3.
- R5: A later byte is announced by one strobe with `snd_n`=1 that carries the new byte. At the following strobe (`snd_n`=0, same byte) `ack_n` rises to 1 as the pre-acknowledge. At the strobe after that, `ack_n` returns to 0 and `byte_vld` pulses with `byte_first`=0 and the byte.
- R6: If the copy at that following strobe differs from the announced byte, the pre-acknowledge is still given. At the next strobe `ack_n` stays 1 and `msg_abort` pulses, and the receiver returns to idle.
- R7: Two consecutive strobes with `snd_n`=1 after an accepted byte make `msg_end` pulse on the second, with `ack_n` at 1, and the receiver returns to idle.
- R8: `ack_n` changes and the three pulses occur only on the clock edge that samples `frame_stb`=1. Inputs are ignored between strobes.
- R9: After an end or an abort, frames with `snd_n` held at 0 open nothing. A new message needs `snd_n` to go 1 and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per frame; inputs are sampled on it |
| snd_n | input | 1 | Send indicator from the far end, active low |
| mon_in | input | DATA_W | Monitor byte of the current frame |
| ack_n | output | 1 | Acknowledge bit for the next frame, active low |
| byte_vld | output | 1 | One-cycle pulse: a byte has been accepted |
| byte_data | output | DATA_W | Accepted byte, valid with `byte_vld` |
| byte_first | output | 1 | Accepted byte is the first of its message |
| msg_end | output | 1 | One-cycle pulse: message closed normally |
| msg_abort | output | 1 | One-cycle pulse: message aborted on a mismatched byte |

## Verification
A wrong protocol state shows up on `ack_n` within one or two frames. A receiver stuck open keeps A low after the sender has stopped. A receiver that drops to idle early raises A before the pre-acknowledge is due. A missed abort leaves A low where it should stay high. Every value of the byte goes through both the first-byte and the later-byte paths, so a wrong reference register shows up on `byte_data` in the same frame as the `byte_vld` pulse. The directed cases (resynchronising on the first byte, aborting, and refusing to reopen without a rising E) are each checked at the exact strobe where `ack_n` or a pulse would differ.

// File: rtl/mon_rx_pkg.sv
`timescale 1ns/1ps
package mon_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FIRST  = 3'd1,
      ST_HOLD   = 3'd2,
      ST_GAP    = 3'd3,
      ST_PREACK = 3'd4
   } rx_state_t;
endpackage

// File: rtl/mon_edge_det.sv
`timescale 1ns/1ps
module mon_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic snd_n,
   output logic snd_fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b1;
      else if (stb) prev_q <= snd_n;
   end

   assign snd_fall = stb & prev_q & ~snd_n;
endmodule

// File: rtl/mon_byte_hold.sv
`timescale 1ns/1ps
module mon_byte_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] ref_q,
   output logic              same
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ref_q <= '0;
      else if (load) ref_q <= din;
   end

   assign same = (din == ref_q);
endmodule

// File: rtl/mon_rx_ctrl.sv
`timescale 1ns/1ps
module mon_rx_ctrl
   import mon_rx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit FIRST_RESYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              snd_n,
   input  logic              snd_fall,
   input  logic              same,
   input  logic [DATA_W-1:0] ref_q,
   output logic              load,
   output logic              ack_n,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_data,
   output logic              byte_first,
   output logic              msg_end,
   output logic              msg_abort
);
   rx_state_t st_q;
   rx_state_t first_miss_st;
   logic      match_q;
   logic      first_miss_load;

   generate
      if (FIRST_RESYNC) begin : g_resync
         assign first_miss_st   = ST_FIRST;
         assign first_miss_load = 1'b1;
      end else begin : g_drop
         assign first_miss_st   = ST_IDLE;
         assign first_miss_load = 1'b0;
      end
   endgenerate

   always_comb begin
      load = 1'b0;
      if (stb) begin
         unique case (st_q)
            ST_IDLE:  load = snd_fall;
            ST_FIRST: load = ~snd_n & ~same & first_miss_load;
            ST_HOLD:  load = snd_n;
            default:  load = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         match_q    <= 1'b0;
         ack_n      <= 1'b1;
         byte_vld   <= 1'b0;
         byte_data  <= '0;
         byte_first <= 1'b0;
         msg_end    <= 1'b0;
         msg_abort  <= 1'b0;
      end else begin
         byte_vld  <= 1'b0;
         msg_end   <= 1'b0;
         msg_abort <= 1'b0;
         if (stb) begin
            unique case (st_q)
               ST_IDLE: begin
                  ack_n <= 1'b1;
                  if (snd_fall) st_q <= ST_FIRST;
               end
               ST_FIRST: begin
                  if (snd_n) begin
                     st_q <= ST_IDLE;
                  end else if (same) begin
                     ack_n      <= 1'b0;
                     byte_vld   <= 1'b1;
                     byte_first <= 1'b1;
                     byte_data  <= ref_q;
                     st_q       <= ST_HOLD;
                  end else begin
                     st_q <= first_miss_st;
                  end
               end
               ST_HOLD: begin
                  if (snd_n) st_q <= ST_GAP;
               end
               ST_GAP: begin
                  ack_n <= 1'b1;
                  if (snd_n) begin
                     msg_end <= 1'b1;
                     st_q    <= ST_IDLE;
                  end else begin
                     match_q <= same;
                     st_q    <= ST_PREACK;
                  end
               end
               ST_PREACK: begin
                  if (match_q) begin
                     ack_n      <= 1'b0;
                     byte_vld   <= 1'b1;
                     byte_first <= 1'b0;
                     byte_data  <= ref_q;
                     st_q       <= ST_HOLD;
                  end else begin
                     msg_abort <= 1'b1;
                     st_q      <= ST_IDLE;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mon_rx.sv
`timescale 1ns/1ps
module mon_rx #(
   parameter int DATA_W       = 8,
   parameter bit FIRST_RESYNC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              snd_n,
   input  logic [DATA_W-1:0] mon_in,
   output logic              ack_n,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_data,
   output logic              byte_first,
   output logic              msg_end,
   output logic              msg_abort
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mon_rx: DATA_W must be at least 1");
      end
   endgenerate

   logic              snd_fall;
   logic              load;
   logic              same;
   logic [DATA_W-1:0] ref_q;

   mon_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (frame_stb),
      .snd_n    (snd_n),
      .snd_fall (snd_fall)
   );

   mon_byte_hold #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .din   (mon_in),
      .ref_q (ref_q),
      .same  (same)
   );

   mon_rx_ctrl #(.DATA_W(DATA_W), .FIRST_RESYNC(FIRST_RESYNC)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (frame_stb),
      .snd_n      (snd_n),
      .snd_fall   (snd_fall),
      .same       (same),
      .ref_q      (ref_q),
      .load       (load),
      .ack_n      (ack_n),
      .byte_vld   (byte_vld),
      .byte_data  (byte_data),
      .byte_first (byte_first),
      .msg_end    (msg_end),
      .msg_abort  (msg_abort)
   );
endmodule

// File: rtl/mon_rx_chk.sv
`timescale 1ns/1ps
module mon_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_stb,
   input logic ack_n,
   input logic byte_vld,
   input logic msg_end,
   input logic msg_abort
);
   AST_PULSE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> !(byte_vld || msg_end || msg_abort)); // R8
   AST_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(ack_n)); // R8
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_vld, msg_end, msg_abort})); // R7
   AST_ABORT_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      msg_abort |-> ack_n); // R6
   AST_END_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end |-> ack_n); // R7
   AST_VLD_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> !ack_n); // R3
   AST_ABORT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_abort |-> $past(ack_n)); // R6
endmodule

bind mon_rx mon_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_stb (frame_stb),
   .ack_n     (ack_n),
   .byte_vld  (byte_vld),
   .msg_end   (msg_end),
   .msg_abort (msg_abort)
);

// File: tb/tb_mon_rx.sv
`timescale 1ns/1ps
module tb_mon_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       snd_n = 1'b1;
   logic [7:0] mon_in = 8'h00;
   logic       ack_n, byte_vld, byte_first, msg_end, msg_abort;
   logic [7:0] byte_data;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   logic       g_a, g_v, g_f, g_e, g_x;
   logic [7:0] g_d;

   always #4 clk = ~clk;

   mon_rx dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .snd_n(snd_n),
      .mon_in(mon_in), .ack_n(ack_n), .byte_vld(byte_vld),
      .byte_data(byte_data), .byte_first(byte_first),
      .msg_end(msg_end), .msg_abort(msg_abort)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one frame: drive, strobe, sample the registered response, idle gap
   task automatic frm(input bit e, input logic [7:0] b);
      @(negedge clk);
      snd_n = e; mon_in = b; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      g_a = ack_n; g_v = byte_vld; g_f = byte_first; g_d = byte_data;
      g_e = msg_end; g_x = msg_abort;
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_frame(input string tag, input bit a, input bit v,
                               input bit f, input logic [7:0] d,
                               input bit e, input bit x);
      chk(g_a == a, {tag, " ack_n"}, g_a, a);
      chk(g_v == v, {tag, " byte_vld"}, g_v, v);
      if (v) begin
         chk(g_f == f, {tag, " byte_first"}, g_f, f);
         chk(g_d == d, {tag, " byte_data"}, g_d, d);
      end
      chk(g_e == e, {tag, " msg_end"}, g_e, e);
      chk(g_x == x, {tag, " msg_abort"}, g_x, x);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ack_n == 1'b1, "R1 reset ack_n", ack_n, 1);
      chk({byte_vld, msg_end, msg_abort} == 3'b000, "R1 reset pulses",
          {byte_vld, msg_end, msg_abort}, 0);
      rst_n = 1'b1;
      frm(1'b1, 8'h00);
      expect_frame("R1 idle", 1, 0, 0, 0, 0, 0);

      // Sweep of every byte value through first and later byte paths
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b0, b1;
         b0 = v[7:0];
         b1 = b0 ^ 8'hA5;
         frm(1'b1, 8'h00);
         frm(1'b0, b0);  expect_frame("R2 open", 1, 0, 0, 0, 0, 0);
         frm(1'b0, b0);  expect_frame("R3 first accept", 0, 1, 1, b0, 0, 0);
         frm(1'b0, b0);  expect_frame("R3 hold", 0, 0, 0, 0, 0, 0);
         frm(1'b1, b1);  expect_frame("R5 announce", 0, 0, 0, 0, 0, 0);
         frm(1'b0, b1);  expect_frame("R5 preack", 1, 0, 0, 0, 0, 0);
         frm(1'b0, b1);  expect_frame("R5 ack", 0, 1, 0, b1, 0, 0);
         frm(1'b1, 8'h00); expect_frame("R7 gap", 0, 0, 0, 0, 0, 0);
         frm(1'b1, 8'h00); expect_frame("R7 end", 1, 0, 0, 0, 1, 0);
         frm(1'b1, 8'h00); expect_frame("R1 after end", 1, 0, 0, 0, 0, 0);
      end

      // R4: first byte copies differ, then resynchronise
      frm(1'b0, 8'h11); expect_frame("R4 open", 1, 0, 0, 0, 0, 0);
      frm(1'b0, 8'h22); expect_frame("R4 mismatch", 1, 0, 0, 0, 0, 0);
      frm(1'b0, 8'h22); expect_frame("R4 accept", 0, 1, 1, 8'h22, 0, 0);

      // R6: later byte copies differ -> preack then abort
      frm(1'b1, 8'h33); expect_frame("R6 announce", 0, 0, 0, 0, 0, 0);
      frm(1'b0, 8'h34); expect_frame("R6 preack", 1, 0, 0, 0, 0, 0);
      frm(1'b0, 8'h34); expect_frame("R6 abort", 1, 0, 0, 0, 0, 1);

      // R9: E still low after abort opens nothing
      frm(1'b0, 8'h55); expect_frame("R9 no reopen", 1, 0, 0, 0, 0, 0);
      frm(1'b0, 8'h55); expect_frame("R9 no accept", 1, 0, 0, 0, 0, 0);
      frm(1'b1, 8'h00);
      frm(1'b0, 8'h66); expect_frame("R9 reopen", 1, 0, 0, 0, 0, 0);

      // R8: input changes without a strobe are ignored
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         snd_n = k[0]; mon_in = 8'h99 + k[7:0];
         @(negedge clk);
         chk(ack_n == 1'b1 && !byte_vld && !msg_end && !msg_abort,
             "R8 no strobe", {ack_n, byte_vld, msg_end, msg_abort}, 4'b1000);
      end
      frm(1'b0, 8'h66); expect_frame("R8 accept after ignored", 0, 1, 1, 8'h66, 0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule